// File: doc/BRIEF.md
# Indexed Halfword Extremum Search Step

This unit performs one step of a running search for the largest or smallest 16-bit element, and for that element's position, across a vector. The caller passes in two things per step: a 64-bit search state, and one 32-bit word that holds two packed 16-bit elements. The unit returns the updated state one clock later. The caller then feeds that state back in with the next word. Walking through memory, looping and the vector length all belong to the caller.

The search state has three packed fields:

- `[15:0]` is the running index: the position of the low element of the current word.
- `[31:16]` is the position of the best element found so far.
- `[47:32]` is the best value found so far.
- `[63:48]` is unused and always returned as zero.

Two mode inputs control the search. One selects maximum or minimum search. The other selects whether elements are compared as two's complement or unsigned values.

The result sits in a single register stage controlled by a two-state machine:

- `STG_EMPTY` means no result is held. `STG_FULL` means a fresh result is on the output.
- The transition *fill* goes to `STG_FULL` on any cycle with `in_valid` high. The new result is captured in that cycle.
- The transition *drain* goes to `STG_EMPTY` on any cycle with `in_valid` low. The output word keeps its last value.

Top module: `hx_search`

## Requirements
- R1: Output bits [15:0] equal the input running index plus 2, modulo 2^16. For example, 0xFFFF becomes 0x0001.
- R2: In maximum mode (`mode_min`=0), the low element (data bits [15:0]) wins when it is at least the high element (data bits [31:16]) and strictly above the carried best value. The output best value then becomes the low element, and the output best index becomes the input running index.
- R3: In maximum mode, when the low element does not win, the high element wins if it is strictly above both the low element and the carried best value. The output best value then becomes the high element, and the output best index becomes the running index plus 1.
- R4: When the two elements are equal and beat the carried best value, the low element wins.
- R5: When neither element wins, output bits [47:16] equal the input bits [47:16]. This includes an element that only equals the carried best value.
- R6: In minimum mode (`mode_min`=1), "above" in R2 to R4 is replaced by "below".
- R7: When `mode_signed`=1, all three 16-bit values are compared as two's complement. When `mode_signed`=0, they are compared as unsigned.
- R8: Output bits [63:48] are always zero, whatever the input bits [63:48] hold.
- R9: `out_valid` is `in_valid` delayed by one clock. The result for inputs sampled at a rising edge appears after that edge. While `in_valid` is low, `out_state` keeps its value.
- R10: During reset, `out_valid` and `out_state` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Step request; the inputs are sampled when it is high |
| in_state | input | 64 | Incoming search state |
| in_data | input | 32 | Two packed 16-bit elements; the low element is at [15:0] |
| mode_min | input | 1 | 1 = minimum search, 0 = maximum search |
| mode_signed | input | 1 | 1 = two's complement compare, 0 = unsigned compare |
| out_valid | output | 1 | High for one cycle per accepted step |
| out_state | output | 64 | Updated search state |

## Verification
The only internal state is the stage register and its two-state tracker. A fault in either shows at the ports on the first cycle after the step that corrupted it. A stuck tracker shows as an `out_valid` that fails to follow `in_valid` one cycle later. A wrongly captured word shows as a wrong index, value or upper field in that same output cycle. A compare fault (wrong signedness, reversed direction, or tie priority lost) changes the best-value and best-index fields in the very next result. For that reason, every result is compared against an independent model in the cycle it appears, and equal-element and equal-to-best cases are forced often.

// File: rtl/hx_pkg.sv
package hx_pkg;

    typedef enum logic [0:0] {
        STG_EMPTY = 1'b0,
        STG_FULL  = 1'b1
    } stg_e;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_LO   = 2'd1,
        PICK_HI   = 2'd2
    } pick_e;

endpackage

// File: rtl/hx_order.sv
module hx_order #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         mode_min,
    input  logic         mode_signed,
    output logic         beats,
    output logic         beats_or_eq
);
    logic signed [W:0] ax;
    logic signed [W:0] bx;
    logic              gt;
    logic              lt;

    always_comb begin
        ax = {mode_signed & a[W-1], a};
        bx = {mode_signed & b[W-1], b};
        gt = ax > bx;
        lt = ax < bx;
        beats = mode_min ? lt : gt;
        beats_or_eq = beats | (a == b);
    end
endmodule

// File: rtl/hx_step.sv
module hx_step
    import hx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [4*W-1:0] st_i,
    input  logic [2*W-1:0] data_i,
    input  logic           mode_min,
    input  logic           mode_signed,
    output logic [4*W-1:0] st_o
);
    localparam int NEL = 2;

    logic [W-1:0] elem [NEL];
    logic [W-1:0] run_idx;
    logic [W-1:0] best_idx;
    logic [W-1:0] best_val;
    logic [NEL-1:0] over_rival;
    logic [NEL-1:0] over_rival_eq;
    logic [NEL-1:0] over_best;
    logic [NEL-1:0] over_best_eq;
    pick_e pick;

    assign elem[0]  = data_i[W-1:0];
    assign elem[1]  = data_i[2*W-1:W];
    assign run_idx  = st_i[W-1:0];
    assign best_idx = st_i[2*W-1:W];
    assign best_val = st_i[3*W-1:2*W];

    for (genvar g = 0; g < NEL; g++) begin : g_el
        hx_order #(.W(W)) u_vs_rival (
            .a           (elem[g]),
            .b           (elem[NEL-1-g]),
            .mode_min    (mode_min),
            .mode_signed (mode_signed),
            .beats       (over_rival[g]),
            .beats_or_eq (over_rival_eq[g])
        );
        hx_order #(.W(W)) u_vs_best (
            .a           (elem[g]),
            .b           (best_val),
            .mode_min    (mode_min),
            .mode_signed (mode_signed),
            .beats       (over_best[g]),
            .beats_or_eq (over_best_eq[g])
        );
    end

    always_comb begin
        if (over_rival_eq[0] && over_best[0]) begin
            pick = PICK_LO;
        end else if (over_rival[1] && over_best[1]) begin
            pick = PICK_HI;
        end else begin
            pick = PICK_NONE;
        end
    end

    always_comb begin
        st_o = '0;
        st_o[W-1:0] = run_idx + W'(2);
        unique case (pick)
            PICK_LO: begin
                st_o[2*W-1:W]   = run_idx;
                st_o[3*W-1:2*W] = elem[0];
            end
            PICK_HI: begin
                st_o[2*W-1:W]   = run_idx + W'(1);
                st_o[3*W-1:2*W] = elem[1];
            end
            default: begin
                st_o[2*W-1:W]   = best_idx;
                st_o[3*W-1:2*W] = best_val;
            end
        endcase
    end

    logic unused_ok;
    assign unused_ok = ^{st_i[4*W-1:3*W], over_rival_eq[1], over_rival[0], over_best_eq};
endmodule

// File: rtl/hx_stage.sv
module hx_stage
    import hx_pkg::*;
#(
    parameter int SW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [SW-1:0] d,
    output logic          out_valid,
    output logic [SW-1:0] q
);
    stg_e state_q;
    stg_e state_d;

    always_comb begin
        unique case (state_q)
            STG_EMPTY: state_d = in_valid ? STG_FULL : STG_EMPTY;
            STG_FULL:  state_d = in_valid ? STG_FULL : STG_EMPTY;
            default:   state_d = STG_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= STG_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (in_valid) begin
            q <= d;
        end
    end

    assign out_valid = (state_q == STG_FULL);
endmodule

// File: rtl/hx_search.sv
module hx_search #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [4*W-1:0] in_state,
    input  logic [2*W-1:0] in_data,
    input  logic           mode_min,
    input  logic           mode_signed,
    output logic           out_valid,
    output logic [4*W-1:0] out_state
);
    localparam int SW = 4 * W;

    logic [SW-1:0] next_state;

    hx_step #(.W(W)) u_step (
        .st_i        (in_state),
        .data_i      (in_data),
        .mode_min    (mode_min),
        .mode_signed (mode_signed),
        .st_o        (next_state)
    );

    hx_stage #(.SW(SW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d         (next_state),
        .out_valid (out_valid),
        .q         (out_state)
    );
endmodule

// File: rtl/hx_search_chk.sv
module hx_search_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [4*W-1:0] in_state,
    input logic           out_valid,
    input logic [4*W-1:0] out_state
);
    a_r1_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_state[W-1:0] == $past(in_state[W-1:0]) + W'(2));

    // R2, R3, R5: the best index is one of the three legal sources
    a_r3_index_source: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_state[2*W-1:W] == $past(in_state[W-1:0]))
                  || (out_state[2*W-1:W] == $past(in_state[W-1:0]) + W'(1))
                  || (out_state[2*W-1:W] == $past(in_state[2*W-1:W])));

    a_r8_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_state[4*W-1:3*W] == '0);

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_state));

    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid && out_state == '0);
endmodule

bind hx_search hx_search_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_state  (in_state),
    .out_valid (out_valid),
    .out_state (out_state)
);

// File: tb/hx_search_tb.sv
module hx_search_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_state = '0;
    logic [31:0] in_data = '0;
    logic        mode_min = 1'b0;
    logic        mode_signed = 1'b0;
    logic        out_valid;
    logic [63:0] out_state;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hx_search u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_state(in_state),
        .in_data(in_data), .mode_min(mode_min), .mode_signed(mode_signed),
        .out_valid(out_valid), .out_state(out_state)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int as_num(input logic [15:0] v, input bit sg);
        return sg ? int'($signed(v)) : int'(v);
    endfunction

    function automatic bit better(input int a, input int b, input bit mn);
        return mn ? (a < b) : (a > b);
    endfunction

    // returns the kind: 0 none, 1 low, 2 high
    function automatic logic [63:0] model(input logic [63:0] s, input logic [31:0] d,
                                          input bit mn, input bit sg, output int kind);
        int lo, hi, ex;
        logic [63:0] r;
        lo = as_num(d[15:0], sg);
        hi = as_num(d[31:16], sg);
        ex = as_num(s[47:32], sg);
        r = '0;
        r[15:0] = s[15:0] + 16'd2;
        if ((better(lo, hi, mn) || lo == hi) && better(lo, ex, mn)) begin
            kind = 1; r[47:32] = d[15:0]; r[31:16] = s[15:0];
        end else if (better(hi, lo, mn) && better(hi, ex, mn)) begin
            kind = 2; r[47:32] = d[31:16]; r[31:16] = s[15:0] + 16'd1;
        end else begin
            kind = 0; r[47:16] = s[47:16];
        end
        return r;
    endfunction

    // drive at a falling edge, check after the next rising edge
    task automatic step(input string tag, input logic [63:0] s, input logic [31:0] d,
                        input bit mn, input bit sg, input logic [63:0] exp);
        in_valid = 1'b1; in_state = s; in_data = d; mode_min = mn; mode_signed = sg;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
        chk(tag, out_state, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] exp_q[$];
        logic [63:0] last;
        logic [63:0] e;
        int kind;
        bit v;

        repeat (3) @(negedge clk);
        chk("R10 valid", {63'd0, out_valid}, 64'd0);
        chk("R10 state", out_state, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: low wins in max mode, signed
        step("R2", 64'h0000_0003_0001_0010, 32'h0004_0009, 0, 1, 64'h0000_0009_0010_0012);
        // R3: high wins, index + 1
        step("R3", 64'h0000_0003_0001_0010, 32'h0009_0004, 0, 1, 64'h0000_0009_0011_0012);
        // R4: equal elements beating best, low preferred
        step("R4", 64'h0000_0003_0001_0020, 32'h0005_0005, 0, 0, 64'h0000_0005_0020_0022);
        // R5: all equal to best, nothing moves
        step("R5 tie", 64'h0000_0005_0007_0020, 32'h0005_0005, 0, 0, 64'h0000_0005_0007_0022);
        // R5: both worse than best
        step("R5 worse", 64'h0000_0050_0007_0030, 32'h0001_0002, 0, 0, 64'h0000_0050_0007_0032);
        // R6: min mode, high strictly smaller
        step("R6 hi", 64'h0000_0010_0000_0004, 32'h0003_0008, 1, 0, 64'h0000_0003_0005_0006);
        // R6: min mode, equal elements below best, low preferred
        step("R6 tie", 64'h0000_0010_0000_0004, 32'h0002_0002, 1, 0, 64'h0000_0002_0004_0006);
        // R7: 0x8000 is smallest signed, largest unsigned
        step("R7 signed", 64'h0000_0000_0000_0000, 32'h0001_8000, 0, 1, 64'h0000_0001_0001_0002);
        step("R7 unsigned", 64'h0000_0000_0000_0000, 32'h0001_8000, 0, 0, 64'h0000_8000_0000_0002);
        // R1: index wrap, R8: upper input bits ignored
        step("R1 R8", 64'hABCD_7FFF_0003_FFFF, 32'h0001_0002, 0, 1, 64'h0000_7FFF_0003_0001);
        // R9: hold while idle
        last = out_state;
        in_state = 64'h1234_5678_9ABC_DEF0; in_data = 32'hFFFF_0000;
        @(negedge clk);
        chk("R9 drop", {63'd0, out_valid}, 64'd0);
        chk("R9 hold", out_state, last);

        // random stream with forced ties, checked every cycle
        last = out_state;
        for (int i = 0; i < 600; i++) begin
            logic [63:0] s;
            logic [31:0] d;
            bit mn, sg;
            s = {$urandom, $urandom};
            d = $urandom;
            mn = 1'($urandom); sg = 1'($urandom);
            if ($urandom_range(0, 3) == 0) d[31:16] = d[15:0];
            if ($urandom_range(0, 3) == 0) s[47:32] = $urandom_range(0, 1) ? d[15:0] : d[31:16];
            v = ($urandom_range(0, 4) != 0);
            in_valid = v; in_state = s; in_data = d; mode_min = mn; mode_signed = sg;
            if (v) exp_q.push_back(model(s, d, mn, sg, kind));
            else kind = -1;
            @(negedge clk);
            if (v) begin
                e = exp_q.pop_front();
                chk("R9 stream valid", {63'd0, out_valid}, 64'd1);
                if (kind == 1) chk("R2 stream", out_state, e);
                else if (kind == 2) chk("R3 stream", out_state, e);
                else chk("R5 stream", out_state, e);
                last = e;
            end else begin
                chk("R9 stream idle", {63'd0, out_valid}, 64'd0);
                chk("R9 stream hold", out_state, last);
            end
        end
        in_valid = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule